// File: doc/BRIEF.md
# Configurable Montgomery Reduction Unit

This block is the reduction step of a number-theoretic-transform butterfly in lattice cryptography. One signed 64-bit value, a modulus and a variant code go in, and one reduced 64-bit value comes out one clock later. A single datapath covers three variants:

- a 16-bit reduction that subtracts,
- a 16-bit reduction that adds,
- a 32-bit reduction that subtracts.

The unit finds the inverse constant for the supplied modulus in a small set of supported moduli. It keeps the low k bits of the product of the input and that constant. It multiplies that truncated value by the modulus, adds it to or subtracts it from the input, and shifts the sum arithmetically right by k.

The supported moduli are parameters; the defaults are 3329, 8380417 and 12289. The inverse constants are computed at elaboration, so the list holds only moduli. If the modulus is not in the list, the unit uses a zero constant and raises an error flag. The reserved variant code also raises the error flag and gives a zero result.

Top module: `mont_reduce_unit`

## Requirements
- R1: With variant code 0 (16-bit subtract), the output is (A − m·q) >>> 16. Here A is the signed input, q is the modulus, m = (A·q′) mod 2^16, and q·q′ ≡ 1 mod 2^16.
- R2: With variant code 1 (16-bit add), the output is (A + m·q) >>> 16. Here m = (A·q′) mod 2^16 and q·q′ ≡ −1 mod 2^16.
- R3: With variant code 2 (32-bit subtract), the output is (A − m·q) >>> 32. Here m = (A·q′) mod 2^32 and q·q′ ≡ 1 mod 2^32.
- R4: Each supported modulus (3329, 8380417, 12289 by default) selects its own inverse constant, and the error flag stays 0 for it.
- R5: For a modulus not in the supported list with variant code 0, 1 or 2, q′ is taken as zero. The output is then A >>> k and the error flag is 1.
- R6: Variant code 3 is reserved. It sets the error flag to 1 and gives an output of zero.
- R7: The input is signed two's complement and the shift is arithmetic, so negative inputs give correctly signed results.
- R8: out_valid is 1 exactly in the cycle after a cycle with in_valid 1. The result and the flag appear together with out_valid.
- R9: While in_valid is 0, out_value and out_error hold their last values, whatever the other inputs do.
- R10: During reset, out_valid, out_value and out_error are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| in_value | input | DATA_W (64) | Signed value to reduce |
| in_modulus | input | MOD_W (24) | Modulus q |
| in_variant | input | 2 | 0 sub16, 1 add16, 2 sub32, 3 reserved |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_value | output | DATA_W (64) | Reduced result |
| out_error | output | 1 | Unsupported modulus or reserved variant |

## Verification
A wrong inverse constant, a wrong truncation width or a wrong add/subtract choice shows up in out_value on the very next cycle after the operand is accepted. The pre-shift low bits no longer cancel, so the result differs from the arithmetic reference by a fraction that has been shifted into the kept bits.

The bench sweeps every supported modulus against every variant. The inputs are corner values and many pseudo-random signed values, and each result is compared with a reference built from a separately derived inverse. A broken output register shows within one cycle, either as a valid pulse of the wrong length or as a result that changes while no input is valid.

// File: rtl/mr_pkg.sv
// Package for the Montgomery reduction unit.
// Holds the variant encoding, the decoded control word, and an
// elaboration-time function that inverts an odd number modulo 2^64.
package mr_pkg;

    typedef enum logic [1:0] {
        MR_SUB16 = 2'd0,
        MR_ADD16 = 2'd1,
        MR_SUB32 = 2'd2,
        MR_RSVD  = 2'd3
    } mr_variant_e;

    typedef struct packed {
        logic wide;   // 1: 32-bit truncation and shift, 0: 16-bit
        logic add;    // 1: add the product, 0: subtract it
        logic rsvd;   // reserved code, result forced to zero
    } mr_ctrl_t;

    // Newton iteration x <- x*(2 - q*x); each pass doubles the correct bits.
    // Assumes q is odd: a start value of q is already correct to 3 bits.
    function automatic logic [63:0] mr_odd_inverse(input logic [63:0] q);
        logic [63:0] x;
        x = q;
        for (int i = 0; i < 6; i++) begin
            x = x * (64'd2 - q * x);
        end
        return x;
    endfunction

endpackage

// File: rtl/mr_decode.sv
// Variant decoder.
// Turns the 2-bit variant code into a control word for truncation
// width, add or subtract, and the reserved case. Purely combinational.
module mr_decode
    import mr_pkg::*;
(
    input  logic [1:0] variant,
    output mr_ctrl_t   ctrl
);

    // Map each variant code onto its control bits.
    always_comb begin
        ctrl = '0;
        unique case (mr_variant_e'(variant))
            MR_SUB16: begin
                ctrl.wide = 1'b0;
                ctrl.add  = 1'b0;
            end
            MR_ADD16: begin
                ctrl.wide = 1'b0;
                ctrl.add  = 1'b1;
            end
            MR_SUB32: begin
                ctrl.wide = 1'b1;
                ctrl.add  = 1'b0;
            end
            default: begin
                ctrl.rsvd = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mr_inv_select.sv
// Inverse constant selector.
// Compares the modulus with every entry of the supported list. The entry
// that matches supplies its inverse, computed at elaboration. The
// inverse is negated for the add variant and cut to the narrow width
// when the narrow variant is chosen. With no match, the constant is
// zero and "hit" is low.
// Assumes every list entry is odd and that K_NARROW < K_WIDE <= 64.
module mr_inv_select
    import mr_pkg::*;
#(
    parameter int NUM_MOD  = 3,
    parameter int MOD_W    = 24,
    parameter int K_WIDE   = 32,
    parameter int K_NARROW = 16,
    parameter logic [NUM_MOD*MOD_W-1:0] MOD_LIST = '0
) (
    input  logic [MOD_W-1:0]  modulus,
    input  mr_ctrl_t          ctrl,
    output logic [K_WIDE-1:0] qinv,
    output logic              hit
);

    localparam int PAD_W = 64 - MOD_W;

    logic [NUM_MOD-1:0] match;
    logic [K_WIDE-1:0]  contrib [NUM_MOD];

    // One comparator and one constant per supported modulus.
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_entry
        localparam logic [MOD_W-1:0] ENTRY = MOD_LIST[i*MOD_W +: MOD_W];
        localparam logic [63:0]      INV64 = mr_odd_inverse({{PAD_W{1'b0}}, ENTRY});
        localparam logic [K_WIDE-1:0] INV  = INV64[K_WIDE-1:0];

        assign match[i]   = (modulus == ENTRY);
        assign contrib[i] = match[i] ? INV : '0;
    end

    logic [K_WIDE-1:0]   sel_inv;
    logic [K_NARROW-1:0] narrow_inv;

    // Merge the per-entry constants; at most one distinct value is non-zero.
    always_comb begin
        sel_inv = '0;
        for (int i = 0; i < NUM_MOD; i++) begin
            sel_inv = sel_inv | contrib[i];
        end
    end

    assign hit = |match;

    // Negate for the add variant and cut to the active width.
    always_comb begin
        narrow_inv = ctrl.add ? (K_NARROW'(0) - sel_inv[K_NARROW-1:0])
                              : sel_inv[K_NARROW-1:0];
        if (ctrl.wide) begin
            qinv = ctrl.add ? (K_WIDE'(0) - sel_inv) : sel_inv;
        end else begin
            qinv = {{(K_WIDE-K_NARROW){1'b0}}, narrow_inv};
        end
    end

endmodule

// File: rtl/mr_datapath.sv
// Reduction datapath.
// Forms the truncated product m = (A * q') mod 2^k, multiplies it by q,
// adds it to or subtracts it from the sign-extended input, and shifts
// right arithmetically by k. The reserved variant gives zero.
// Assumes K_WIDE + MOD_W < DATA_W, so the sum fits in DATA_W+2 bits.
module mr_datapath
    import mr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int MOD_W    = 24,
    parameter int K_WIDE   = 32,
    parameter int K_NARROW = 16
) (
    input  logic [DATA_W-1:0] value,
    input  logic [MOD_W-1:0]  modulus,
    input  logic [K_WIDE-1:0] qinv,
    input  mr_ctrl_t          ctrl,
    output logic [DATA_W-1:0] result
);

    localparam int MQ_W  = K_WIDE + MOD_W;
    localparam int EXT_W = DATA_W + 2;

    logic [K_WIDE-1:0]        prod_lo;
    logic [K_WIDE-1:0]        m_trunc;
    logic [MQ_W-1:0]          mq;
    logic signed [EXT_W-1:0]  a_ext;
    logic signed [EXT_W-1:0]  mq_ext;
    logic signed [EXT_W-1:0]  sum;
    logic signed [EXT_W-1:0]  shifted;

    // Truncated product: only the low K_WIDE bits are ever needed.
    always_comb begin
        prod_lo = value[K_WIDE-1:0] * qinv;
        m_trunc = ctrl.wide ? prod_lo
                            : {{(K_WIDE-K_NARROW){1'b0}}, prod_lo[K_NARROW-1:0]};
    end

    // Full product of the truncated value and the modulus.
    always_comb begin
        mq = {{MOD_W{1'b0}}, m_trunc} * {{K_WIDE{1'b0}}, modulus};
    end

    // Signed accumulate, then arithmetic shift by the active width.
    always_comb begin
        a_ext   = {{2{value[DATA_W-1]}}, value};
        mq_ext  = {{(EXT_W-MQ_W){1'b0}}, mq};
        sum     = ctrl.add ? (a_ext + mq_ext) : (a_ext - mq_ext);
        shifted = ctrl.wide ? (sum >>> K_WIDE) : (sum >>> K_NARROW);
        result  = ctrl.rsvd ? '0 : shifted[DATA_W-1:0];
    end

endmodule

// File: rtl/mont_reduce_unit.sv
// Configurable Montgomery reduction unit (top).
// Single-cycle reduction with a registered output: an operand accepted
// with in_valid appears on out_value one clock later, with out_valid.
// The outputs hold while no operand is accepted. Reset is synchronous
// and active low.
module mont_reduce_unit
    import mr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int MOD_W    = 24,
    parameter int K_WIDE   = 32,
    parameter int K_NARROW = 16,
    parameter int NUM_MOD  = 3,
    parameter logic [NUM_MOD*MOD_W-1:0] MOD_LIST =
        {24'd12289, 24'd8380417, 24'd3329}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic [MOD_W-1:0]  in_modulus,
    input  logic [1:0]        in_variant,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value,
    output logic              out_error
);

    mr_ctrl_t          ctrl;
    logic [K_WIDE-1:0] qinv;
    logic              hit;
    logic [DATA_W-1:0] result;
    logic              error_c;

    mr_decode u_decode (
        .variant (in_variant),
        .ctrl    (ctrl)
    );

    mr_inv_select #(
        .NUM_MOD  (NUM_MOD),
        .MOD_W    (MOD_W),
        .K_WIDE   (K_WIDE),
        .K_NARROW (K_NARROW),
        .MOD_LIST (MOD_LIST)
    ) u_inv (
        .modulus (in_modulus),
        .ctrl    (ctrl),
        .qinv    (qinv),
        .hit     (hit)
    );

    mr_datapath #(
        .DATA_W   (DATA_W),
        .MOD_W    (MOD_W),
        .K_WIDE   (K_WIDE),
        .K_NARROW (K_NARROW)
    ) u_dp (
        .value   (in_value),
        .modulus (in_modulus),
        .qinv    (qinv),
        .ctrl    (ctrl),
        .result  (result)
    );

    // Error when the code is reserved or the modulus is not in the list.
    assign error_c = ctrl.rsvd | ~hit;

    // Output register: capture on accepted operands, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_error <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_value <= result;
                out_error <= error_c;
            end
        end
    end

endmodule

// File: rtl/mr_checker.sv
// Port-level checker for mont_reduce_unit, attached by bind.
// Relates the accepted operands to the outputs one cycle later.
module mr_checker #(
    parameter int DATA_W  = 64,
    parameter int MOD_W   = 24,
    parameter int NUM_MOD = 3,
    parameter logic [NUM_MOD*MOD_W-1:0] MOD_LIST = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_value,
    input logic [MOD_W-1:0]  in_modulus,
    input logic [1:0]        in_variant,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_value,
    input logic              out_error
);

    logic [NUM_MOD-1:0] listed;

    // Membership of the modulus in the supported list.
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_list
        assign listed[i] = (in_modulus == MOD_LIST[i*MOD_W +: MOD_W]);
    end

    // R10: the cycle after reset is held, every output is zero.
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_value == '0 && !out_error));

    // R8: an accepted operand gives a valid result on the next cycle.
    assert_valid_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: no operand, no valid result on the next cycle.
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: the outputs hold while no operand is accepted.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_value) && $stable(out_error)));

    // R6: the reserved code raises the flag and gives zero.
    assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_variant == 2'd3) |=> (out_error && out_value == '0));

    // R5: a modulus outside the list raises the flag.
    assert_unlisted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && listed == '0) |=> out_error);

    // R4: a listed modulus with a defined code leaves the flag clear.
    assert_listed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && listed != '0 && in_variant != 2'd3) |=> !out_error);

    // R7: a zero input reduces to zero under every defined code.
    assert_zero_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_value == '0) |=> (out_value == '0));

endmodule

bind mont_reduce_unit mr_checker #(
    .DATA_W   (DATA_W),
    .MOD_W    (MOD_W),
    .NUM_MOD  (NUM_MOD),
    .MOD_LIST (MOD_LIST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_value   (in_value),
    .in_modulus (in_modulus),
    .in_variant (in_variant),
    .out_valid  (out_valid),
    .out_value  (out_value),
    .out_error  (out_error)
);

// File: tb/sim_mont_reduce_unit.sv
`timescale 1ns/1ps
// Bench: sweeps every listed modulus against every code with corner
// and pseudo-random signed inputs. The reference uses an inverse
// derived bit by bit (Hensel lifting) in wide signed arithmetic.
module sim_mont_reduce_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_value = '0;
    logic [23:0] in_modulus = '0;
    logic [1:0]  in_variant = '0;
    logic        out_valid;
    logic [63:0] out_value;
    logic        out_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] lcg = 64'h1234_5678_9abc_def1;

    always #2 clk = ~clk;

    mont_reduce_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_value   (in_value),
        .in_modulus (in_modulus),
        .in_variant (in_variant),
        .out_valid  (out_valid),
        .out_value  (out_value),
        .out_error  (out_error)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inverse of odd q modulo 2^32, one bit at a time.
    function automatic logic [31:0] lift_inv(input logic [31:0] q);
        logic [31:0] x;
        x = 32'd1;
        for (int i = 1; i < 32; i++) begin
            logic [31:0] p;
            p = q * x;
            if (p[i]) x[i] = 1'b1;
        end
        return x;
    endfunction

    function automatic logic [63:0] ref_val(input logic [63:0] a, input logic [31:0] q,
                                             input int v, input bit listed);
        int k;
        logic [127:0] kmask, inv, m, t, ax;
        logic signed [127:0] r;
        if (v == 3) return 64'd0;
        k     = (v == 2) ? 32 : 16;
        kmask = (128'd1 << k) - 128'd1;
        inv   = listed ? {96'd0, lift_inv(q)} : 128'd0;
        if (v == 1) inv = (128'd0 - inv);
        inv   = inv & kmask;
        m     = ({64'd0, a} * inv) & kmask;
        ax    = {{64{a[63]}}, a};
        t     = (v == 1) ? (ax + m * {96'd0, q}) : (ax - m * {96'd0, q});
        r     = $signed(t) >>> k;
        return r[63:0];
    endfunction

    function automatic logic [63:0] next_rand();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg;
    endfunction

    // Apply one operand, check the result, then check one idle cycle.
    task automatic run_op(input logic [63:0] a, input logic [23:0] q, input int v,
                          input bit listed);
        logic [63:0] exp_v;
        logic        exp_e;
        string       tag;
        exp_v = ref_val(a, {8'd0, q}, v, listed);
        exp_e = (v == 3) || !listed;
        if (v == 3)        tag = "R6";
        else if (!listed)  tag = "R5";
        else if (a[63])    tag = "R7";
        else if (v == 0)   tag = "R1";
        else if (v == 1)   tag = "R2";
        else               tag = "R3";
        @(negedge clk);
        in_valid   = 1'b1;
        in_value   = a;
        in_modulus = q;
        in_variant = v[1:0];
        @(negedge clk);
        in_valid   = 1'b0;
        in_value   = next_rand();
        in_modulus = 24'd3329;
        in_variant = 2'd0;
        check("R8 out_valid", {63'd0, out_valid}, 64'd1);
        check({tag, " out_value"}, out_value, exp_v);
        check({(listed ? "R4" : tag), " out_error"}, {63'd0, out_error}, {63'd0, exp_e});
        @(negedge clk);
        check("R8 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R9 hold out_value", out_value, exp_v);
        check("R9 hold out_error", {63'd0, out_error}, {63'd0, exp_e});
    endtask

    initial begin
        logic [23:0] mods [3];
        logic [63:0] corners [8];
        mods[0] = 24'd3329; mods[1] = 24'd8380417; mods[2] = 24'd12289;
        corners[0] = 64'd0;
        corners[1] = 64'd1;
        corners[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        corners[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[4] = 64'h8000_0000_0000_0000;
        corners[5] = 64'h0000_0000_0000_FFFF;
        corners[6] = 64'hFFFF_FFFF_8000_0000;
        corners[7] = 64'h0000_0001_0000_0000;

        // R10: outputs clear while reset is held.
        in_valid = 1'b1;
        in_value = 64'hDEAD_BEEF_0000_1111;
        repeat (3) @(negedge clk);
        check("R10 out_valid", {63'd0, out_valid}, 64'd0);
        check("R10 out_value", out_value, 64'd0);
        check("R10 out_error", {63'd0, out_error}, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R7: every listed modulus under every defined code.
        for (int mi = 0; mi < 3; mi++) begin
            for (int v = 0; v < 3; v++) begin
                for (int c = 0; c < 8; c++) run_op(corners[c], mods[mi], v, 1'b1);
                run_op(64'd3 * {40'd0, mods[mi]}, mods[mi], v, 1'b1);
                run_op(-(64'd7 * {40'd0, mods[mi]}), mods[mi], v, 1'b1);
                for (int r = 0; r < 60; r++) begin
                    logic [63:0] a;
                    a = next_rand();
                    if (r % 3 == 0) a = {{32{a[40]}}, a[31:0]};
                    run_op(a, mods[mi], v, 1'b1);
                end
            end
        end

        // R5: moduli outside the list.
        for (int v = 0; v < 3; v++) begin
            for (int r = 0; r < 10; r++) begin
                run_op(next_rand(), 24'd7681, v, 1'b0);
                run_op(next_rand(), 24'd3331, v, 1'b0);
            end
        end

        // R6: the reserved code with listed and unlisted moduli.
        for (int r = 0; r < 10; r++) begin
            run_op(next_rand(), mods[r % 3], 3, 1'b1);
            run_op(next_rand(), 24'd17, 3, 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule